// File: doc/BRIEF.md
# Stereo serial audio output buffer

This block sits between a register bus and a stereo serial audio pin. Software or a DMA engine writes left and right samples into two short queues, one per channel. An externally generated bit clock and word-select drive a serializer. At the start of each stereo frame, the serializer takes one left sample and one right sample together. It then shifts each sample out MSB first while word-select marks the channel.

Each queue reports when it is empty and when it is at most half full, so that a service routine knows how many samples it may write. Each channel also keeps a sticky underrun flag and a sticky overflow flag. A mask register, where a 0 bit enables a condition, gates the six interrupt conditions onto one interrupt line. Both the bit clock and word-select are sampled in the system clock domain. The serial output changes shortly after each bit-clock falling edge and is meant to be captured on the rising edge.

Top module: `stereo_out_buf`

## Requirements
- R1: After reset, the status register reads 0x0F (both queues empty and half-empty). The mask reads 0x3F (all conditions disabled), and irqOut and serialOut are 0.
- R2: A write to address 0 queues a left sample and a write to address 1 queues a right sample, up to DEPTH samples each. Status bit 0 / bit 2 is 1 while the left / right queue holds no sample. Bit 1 / bit 3 is 1 while that queue holds at most DEPTH/2 samples.
- R3: A write to a full queue is dropped and leaves the queued data unchanged. It sets a sticky overflow bit: status bit 6 for left, bit 7 for right.
- R4: Each time word-select falls (1 to 0), one left and one right sample leave their queues together. The left sample is sent while word-select is low and the right sample while it is high. Each sample goes out MSB first, with the MSB appearing one bit clock after the word-select transition.
- R5: In a half frame longer than SAMPLE_W bit clocks, every bit after the LSB is 0.
- R6: If a queue is empty when a frame starts, that channel sends an all-zero word and its sticky underrun bit is set (bit 4 left, bit 5 right). The other channel is unaffected.
- R7: Writing to the status address (2) clears each sticky bit (4 to 7) where the written bit is 1. The level bits 0 to 3 are unaffected by such a write.
- R8: irqOut is the OR of status bits 0 to 5, each taken only when the mask bit at the same position is 0. The overflow bits never raise irqOut.
- R9: The mask register at address 3 takes written bits 5:0 and reads them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address: 0 left data, 1 right data, 2 status, 3 mask |
| busWrData | input | SAMPLE_W | Write data |
| busRdData | output | SAMPLE_W | Read data for busAddr (combinational) |
| bitClkIn | input | 1 | External serial bit clock |
| wordSelIn | input | 1 | External word-select, low for left |
| serialOut | output | 1 | Serial audio data |
| irqOut | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with SAMPLE_W = 8 and DEPTH = 4. With these values a stereo frame lasts only a few hundred system clocks, so one run can fill the queues to overflow, drain them across several frames, refill them mid-stream and starve each channel into underrun. The word-select half period is first set equal to SAMPLE_W, so the LSB shares a bit clock with the next transition. It is then stretched by three bit clocks to show the zero padding.

// File: rtl/stereo_out_pkg.sv
package stereo_out_pkg;

  typedef struct packed {
    logic popPair;   // take one left and one right sample
    logic loadLeft;  // start shifting the held left word
    logic loadRight; // start shifting the held right word
    logic shiftBit;  // advance the serial word by one bit
  } ser_strobe_t;

  localparam logic [1:0] ADDR_LEFT   = 2'd0;
  localparam logic [1:0] ADDR_RIGHT  = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam logic [1:0] ADDR_MASK   = 2'd3;

  localparam int ST_UNDER_BASE = 4;
  localparam int ST_OVF_BASE   = 6;
  localparam int MASK_W        = 6;

endpackage

// File: rtl/stereo_out_fifo.sv
module stereo_out_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             pushOk, popOk;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign pushOk = push && !full;
  assign popOk  = pop && !empty;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= stepPtr(wrPtr);
      if (popOk)  rdPtr <= stepPtr(rdPtr);
      case ({pushOk, popOk})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/stereo_out_ctrl.sv
module stereo_out_ctrl
  import stereo_out_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitClkIn,
  input  logic        wordSelIn,
  output ser_strobe_t strb
);

  logic [1:0] bclkSync;
  logic [1:0] wsSync;
  logic       bclkPrev;
  logic       wsPrev;
  logic       pending;
  logic       pendChan;
  logic       fallEdge;
  logic       wsNow;
  logic       wsChanged;

  assign wsNow     = wsSync[1];
  assign fallEdge  = bclkPrev && !bclkSync[1];
  assign wsChanged = (wsNow != wsPrev);

  // word-select idles high so that the first low phase opens a frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkSync <= '0;
      wsSync   <= '1;
      bclkPrev <= 1'b0;
      wsPrev   <= 1'b1;
      pending  <= 1'b0;
      pendChan <= 1'b1;
    end else begin
      bclkSync <= {bclkSync[0], bitClkIn};
      wsSync   <= {wsSync[0], wordSelIn};
      bclkPrev <= bclkSync[1];
      if (fallEdge) begin
        wsPrev   <= wsNow;
        pending  <= wsChanged;
        pendChan <= wsNow;
      end
    end
  end

  always_comb begin
    strb.popPair   = fallEdge && wsChanged && !wsNow;
    strb.loadLeft  = fallEdge && pending && !pendChan;
    strb.loadRight = fallEdge && pending && pendChan;
    strb.shiftBit  = fallEdge && !pending;
  end

endmodule

// File: rtl/stereo_out_dp.sv
module stereo_out_dp
  import stereo_out_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int DEPTH    = 4,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ser_strobe_t         strb,
  input  logic                busWrEn,
  input  logic [1:0]          busAddr,
  input  logic [SAMPLE_W-1:0] busWrData,
  output logic [SAMPLE_W-1:0] busRdData,
  output logic                serialOut,
  output logic                irqOut,
  output logic [CNT_W-1:0]    leftCount,
  output logic [CNT_W-1:0]    rightCount,
  output logic [7:0]          statusVec,
  output logic [MASK_W-1:0]   maskVec
);

  logic [1:0][SAMPLE_W-1:0] headV;
  logic [1:0][SAMPLE_W-1:0] holdV;
  logic [1:0][CNT_W-1:0]    cntV;
  logic [1:0]               pushV, fullV, emptyV, halfV, underV, ovfV;
  logic                     clrStb;
  logic [SAMPLE_W-1:0]      shReg;
  logic [MASK_W-1:0]        maskQ;

  assign clrStb = busWrEn && (busAddr == ADDR_STATUS);

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic [SAMPLE_W-1:0] holdQ;
    logic                underQ;
    logic                ovfQ;

    assign pushV[ch] = busWrEn && (busAddr == 2'(ch));
    assign halfV[ch] = (cntV[ch] <= CNT_W'(DEPTH / 2));

    stereo_out_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rstN  (rstN),
      .push  (pushV[ch]),
      .pop   (strb.popPair),
      .din   (busWrData),
      .dout  (headV[ch]),
      .count (cntV[ch]),
      .full  (fullV[ch]),
      .empty (emptyV[ch])
    );

    always_ff @(posedge clk) begin
      if (!rstN) begin
        holdQ  <= '0;
        underQ <= 1'b0;
        ovfQ   <= 1'b0;
      end else begin
        if (strb.popPair) holdQ <= emptyV[ch] ? '0 : headV[ch];
        underQ <= (strb.popPair && emptyV[ch]) ||
                  (underQ && !(clrStb && busWrData[ST_UNDER_BASE + ch]));
        ovfQ   <= (pushV[ch] && fullV[ch]) ||
                  (ovfQ && !(clrStb && busWrData[ST_OVF_BASE + ch]));
      end
    end

    assign holdV[ch]  = holdQ;
    assign underV[ch] = underQ;
    assign ovfV[ch]   = ovfQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
      maskQ <= '1;
    end else begin
      if (strb.loadLeft)       shReg <= holdV[0];
      else if (strb.loadRight) shReg <= holdV[1];
      else if (strb.shiftBit)  shReg <= {shReg[SAMPLE_W-2:0], 1'b0};
      if (busWrEn && (busAddr == ADDR_MASK)) maskQ <= busWrData[MASK_W-1:0];
    end
  end

  assign serialOut  = shReg[SAMPLE_W-1];
  assign statusVec  = {ovfV[1], ovfV[0], underV[1], underV[0],
                       halfV[1], emptyV[1], halfV[0], emptyV[0]};
  assign irqOut     = |(statusVec[MASK_W-1:0] & ~maskQ);
  assign maskVec    = maskQ;
  assign leftCount  = cntV[0];
  assign rightCount = cntV[1];

  always_comb begin
    case (busAddr)
      ADDR_STATUS: busRdData = SAMPLE_W'(statusVec);
      ADDR_MASK:   busRdData = SAMPLE_W'(maskQ);
      default:     busRdData = '0;
    endcase
  end

endmodule

// File: rtl/stereo_out_buf.sv
module stereo_out_buf
  import stereo_out_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int DEPTH    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [1:0]          busAddr,
  input  logic [SAMPLE_W-1:0] busWrData,
  output logic [SAMPLE_W-1:0] busRdData,
  input  logic                bitClkIn,
  input  logic                wordSelIn,
  output logic                serialOut,
  output logic                irqOut
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  ser_strobe_t       strb;
  logic [CNT_W-1:0]  leftCount, rightCount;
  logic [7:0]        statusVec;
  logic [MASK_W-1:0] maskVec;

  stereo_out_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitClkIn  (bitClkIn),
    .wordSelIn (wordSelIn),
    .strb      (strb)
  );

  stereo_out_dp #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busWrEn    (busWrEn),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .serialOut  (serialOut),
    .irqOut     (irqOut),
    .leftCount  (leftCount),
    .rightCount (rightCount),
    .statusVec  (statusVec),
    .maskVec    (maskVec)
  );

endmodule

// File: rtl/stereo_out_buf_chk.sv
module stereo_out_buf_chk #(
  parameter int SAMPLE_W = 16,
  parameter int DEPTH    = 4,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input logic                clk,
  input logic                rstN,
  input logic                busWrEn,
  input logic [1:0]          busAddr,
  input logic [SAMPLE_W-1:0] busWrData,
  input logic                irqOut,
  input logic                popStb,
  input logic [CNT_W-1:0]    leftCount,
  input logic [CNT_W-1:0]    rightCount,
  input logic [7:0]          statusVec,
  input logic [5:0]          maskVec
);

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (leftCount <= CNT_W'(DEPTH)) && (rightCount <= CNT_W'(DEPTH)));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!popStb && !busWrEn) |=> ($stable(leftCount) && $stable(rightCount)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd0 && leftCount == CNT_W'(DEPTH)) |=> statusVec[6]);

  p_pair_pop_left_r4: assert property (@(posedge clk) disable iff (!rstN)
    (popStb && leftCount != '0 && !(busWrEn && busAddr == 2'd0))
      |=> leftCount == $past(leftCount) - CNT_W'(1));

  p_pair_pop_right_r4: assert property (@(posedge clk) disable iff (!rstN)
    (popStb && rightCount != '0 && !(busWrEn && busAddr == 2'd1))
      |=> rightCount == $past(rightCount) - CNT_W'(1));

  p_under_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (popStb && rightCount == '0) |=> statusVec[5]);

  p_under_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statusVec[4] && !(busWrEn && busAddr == 2'd2 && busWrData[4])) |=> statusVec[4]);

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec == 6'h3F) |-> !irqOut);

endmodule

bind stereo_out_buf stereo_out_buf_chk #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .busWrEn    (busWrEn),
  .busAddr    (busAddr),
  .busWrData  (busWrData),
  .irqOut     (irqOut),
  .popStb     (strb.popPair),
  .leftCount  (leftCount),
  .rightCount (rightCount),
  .statusVec  (statusVec),
  .maskVec    (maskVec)
);

// File: tb/stereo_out_buf_tb_top.sv
module stereo_out_buf_tb_top;

  localparam int W     = 8;
  localparam int DEPTH = 4;
  localparam int HALF  = 8; // system clocks per bit-clock phase

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busWrEn = 1'b0;
  logic [1:0]   busAddr = 2'd0;
  logic [W-1:0] busWrData = '0;
  logic [W-1:0] busRdData;
  logic         bclk = 1'b0;
  logic         ws = 1'b1;
  logic         serialOut;
  logic         irqOut;

  int checks = 0;
  int errors = 0;
  int frames = 0;
  bit run = 1'b0;
  bit done = 1'b0;
  int halfLen = W;
  int divCnt = 0;
  int fallCnt = 0;

  logic [W-1:0] mL[$];
  logic [W-1:0] mR[$];

  stereo_out_buf #(.SAMPLE_W(W), .DEPTH(DEPTH)) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .bitClkIn  (bclk),
    .wordSelIn (ws),
    .serialOut (serialOut),
    .irqOut    (irqOut)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // bit clock and word-select: word-select moves on bit-clock falling edges
  always @(negedge clk) begin
    if (run) begin
      divCnt++;
      if (divCnt == HALF) begin
        divCnt = 0;
        bclk = ~bclk;
        if (!bclk) begin
          fallCnt++;
          if (fallCnt >= halfLen) begin
            fallCnt = 0;
            ws = ~ws;
          end
        end
      end
    end
  end

  // monitor: rebuilds words on bit-clock rising edges and compares with the scoreboard
  logic         prevWs = 1'b1;
  bit           armed = 1'b0;
  int           bitCnt = 0;
  logic         chan = 1'b0;
  logic [W-1:0] word = '0;
  logic [W-1:0] curL = '0, curR = '0;
  bit           undL = 1'b0, undR = 1'b0;

  always @(posedge bclk) begin
    if (armed) begin
      if (bitCnt < W) begin
        word = {word[W-2:0], serialOut};
        bitCnt++;
        if (bitCnt == W) begin
          if (!chan) chk(undL ? "R6 left zero word" : "R4 left word", int'(word), int'(curL));
          else       chk(undR ? "R6 right zero word" : "R4 right word", int'(word), int'(curR));
        end
      end else begin
        chk("R5 padding bit", int'(serialOut), 0);
      end
    end
    if (ws != prevWs) begin
      armed  = 1'b1;
      bitCnt = 0;
      word   = '0;
      chan   = ws;
      if (!ws) begin
        undL = (mL.size() == 0);
        undR = (mR.size() == 0);
        curL = undL ? '0 : mL.pop_front();
        curR = undR ? '0 : mR.pop_front();
        frames++;
      end
    end
    prevWs = ws;
  end

  task automatic busWrite(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  // driver: writes a sample and records what the serializer must later send
  task automatic pushSample(input bit right, input logic [W-1:0] d);
    busWrite(right ? 2'd1 : 2'd0, d);
    if (right) begin
      if (mR.size() < DEPTH) mR.push_back(d);
    end else begin
      if (mL.size() < DEPTH) mL.push_back(d);
    end
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] rd;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(2'd2, rd); chk("R1 status after reset", int'(rd), 'h0F);
    busRead(2'd3, rd); chk("R1 mask after reset", int'(rd), 'h3F);
    chk("R1 irq after reset", int'(irqOut), 0);
    chk("R1 serial after reset", int'(serialOut), 0);

    // R9 mask readback, R8 enable left-empty only
    busWrite(2'd3, 8'h2A); busRead(2'd3, rd); chk("R9 mask readback", int'(rd), 'h2A);
    busWrite(2'd3, 8'hFE); busRead(2'd3, rd); chk("R9 mask upper bits ignored", int'(rd), 'h3E);
    chk("R8 irq on unmasked left empty", int'(irqOut), 1);

    // R2 fill levels
    pushSample(1'b0, 8'hA0);
    chk("R8 irq clears when left not empty", int'(irqOut), 0);
    pushSample(1'b0, 8'hA1);
    busRead(2'd2, rd); chk("R2 left half at two", int'(rd), 'h0E);
    pushSample(1'b0, 8'hA2);
    busRead(2'd2, rd); chk("R2 left above half", int'(rd), 'h0C);
    pushSample(1'b0, 8'hA3);

    // R3 overflow on both channels
    pushSample(1'b0, 8'hEE);
    busRead(2'd2, rd); chk("R3 left overflow sticky", int'(rd), 'h4C);
    for (int i = 0; i < 4; i++) pushSample(1'b1, 8'(8'h50 + i));
    pushSample(1'b1, 8'h5F);
    busRead(2'd2, rd); chk("R3 right overflow sticky", int'(rd), 'hC0);
    busWrite(2'd3, 8'h00);
    chk("R8 overflow never interrupts", int'(irqOut), 0);

    // R7 selective write-one-to-clear
    busWrite(2'd2, 8'h40); busRead(2'd2, rd); chk("R7 clear left overflow only", int'(rd), 'h80);
    busWrite(2'd2, 8'h80); busRead(2'd2, rd); chk("R7 clear right overflow", int'(rd), 'h00);
    busWrite(2'd3, 8'h1F); // only right underrun enabled

    // R4 streaming with refills, then R6 underrun
    run = 1'b1;
    wait (frames >= 1); repeat (4) @(negedge clk);
    pushSample(1'b0, 8'hB0); pushSample(1'b1, 8'h60);
    wait (frames >= 2); repeat (4) @(negedge clk);
    pushSample(1'b0, 8'hB1); pushSample(1'b1, 8'h61);
    wait (frames >= 6); repeat (4) @(negedge clk);
    busRead(2'd2, rd); chk("R6 no underrun while data lasts", int'(rd & 8'h30), 'h00);
    chk("R8 irq idle before underrun", int'(irqOut), 0);
    pushSample(1'b0, 8'hC3);
    wait (frames >= 7); repeat (20) @(negedge clk);
    busRead(2'd2, rd); chk("R6 right underrun only", int'(rd & 8'h30), 'h20);
    chk("R8 irq on right underrun", int'(irqOut), 1);
    wait (frames >= 8); repeat (20) @(negedge clk);
    run = 1'b0;
    busRead(2'd2, rd); chk("R6 both underrun", int'(rd), 'h3F);

    // R7 clear sticky bits, level bits untouched
    busWrite(2'd2, 8'h30); busRead(2'd2, rd); chk("R7 underrun cleared", int'(rd), 'h0F);
    busWrite(2'd2, 8'h0F); busRead(2'd2, rd); chk("R7 level bits unaffected", int'(rd), 'h0F);
    chk("R8 irq drops after clear", int'(irqOut), 0);

    // R5 stretched half frame with zero padding
    pushSample(1'b0, 8'h81); pushSample(1'b1, 8'h7E);
    pushSample(1'b0, 8'h3C); pushSample(1'b1, 8'hC3);
    halfLen = W + 3;
    run = 1'b1;
    wait (frames >= 11); repeat (4) @(negedge clk);
    run = 1'b0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule